// File: doc/BRIEF.md
# Masked PC Breakpoint Trigger Unit

This unit watches the program counter of a processor core and raises a breakpoint trigger when the counter matches a programmed address. A per-bit mask removes chosen bits from the comparison, so one breakpoint can cover an aligned range of addresses. The debug logic programs the unit through a small write-only register port. Each write names a 5-bit register index. Three indices belong to this unit: the breakpoint address, the mask, and a trigger-definition word.

The trigger-definition word has a low half and a high half. The low half sets up the first level and the high half sets up the second level. If only one level enables the PC comparison, every qualifying match fires the trigger. If both levels enable it, the unit works as a two-step sequencer. The first match arms the unit and a later match fires. The trigger leaves the unit as a one-cycle registered pulse. The processor halt logic uses this pulse.

Top module: `pc_break_trig`

## Requirements
- R1: After reset the address, mask and trigger-definition registers are all zero, the unit is disarmed, and `trig_pulse` stays low.
- R2: A write with `wr_en` high stores `wr_data` on the next clock edge. Index 5'h08 selects the breakpoint address, index 5'h09 the mask, and index 5'h07 the trigger-definition word. A match evaluated in the same cycle as a write still uses the register values from before that write.
- R3: A mask bit of 1 excludes the matching PC bit from the comparison. A mask bit of 0 requires the PC bit to equal the address bit.
- R4: The PC is compared only in cycles where `pc_valid` is high. A matching PC with `pc_valid` low never causes a trigger.
- R5: A qualifying match produces `trig_pulse` high for exactly the following cycle.
- R6: Bit 0 of the trigger-definition word enables the first level and bit 16 enables the second level. With both bits clear the unit never triggers.
- R7: When exactly one of bits 0 and 16 is set, every qualifying match fires a pulse.
- R8: When bits 0 and 16 are both set, a match while disarmed arms the unit and produces no pulse. A match while armed fires a pulse and disarms the unit.
- R9: Any write to the trigger-definition index disarms the unit. A match in the same cycle is still judged against the old word and the old armed state.
- R10: A write to any index other than 5'h07, 5'h08 or 5'h09 changes no state of the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the unit releases it synchronously inside |
| wr_en | input | 1 | Debug register write strobe |
| wr_idx | input | 5 | Debug register index of the write |
| wr_data | input | 32 | Write data |
| pc_valid | input | 1 | The PC on `pc` is valid this cycle |
| pc | input | 32 | Program counter of the core |
| trig_pulse | output | 1 | One-cycle breakpoint trigger |

## Verification
Two functions can fall in the same cycle: a register write and a qualifying PC match. The most delicate case is a rewrite of the trigger-definition word while the unit is armed and the PC matches. The bench provokes this on purpose, first in a directed step and then many times in a random phase that mixes writes to every index with PCs near the breakpoint. A cycle-accurate behavioural model judges each case. In that model the match uses the old registers and old armed state, a pulse appears one cycle later, and the unit ends the cycle disarmed.

// File: rtl/pcbk_pkg.sv
package pcbk_pkg;
  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] IDX_TDEF = 5'h07;
  localparam logic [IDX_W-1:0] IDX_ADDR = 5'h08;
  localparam logic [IDX_W-1:0] IDX_MASK = 5'h09;
  localparam int TDEF_W  = 32;
  localparam int HALF_W  = TDEF_W / 2;
  localparam int L1_BIT  = 0;            // PC enable of first level
  localparam int L2_BIT  = HALF_W + 0;   // PC enable of second level
  typedef enum logic [1:0] {MODE_OFF, MODE_ONE, MODE_TWO} trig_mode_e;
endpackage

// File: rtl/pcbk_regs.sv
module pcbk_regs
  import pcbk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [AW-1:0]     wr_data,
  output logic [AW-1:0]     bp_addr,
  output logic [AW-1:0]     bp_mask,
  output logic              l1_en,
  output logic              l2_en,
  output logic              tdef_wr
);
  logic          sel_addr, sel_mask, sel_tdef;
  logic [AW-1:0] addr_d, mask_d;
  logic          l1_d, l2_d;

  always_comb begin
    sel_addr = wr_en && (wr_idx == IDX_ADDR);
    sel_mask = wr_en && (wr_idx == IDX_MASK);
    sel_tdef = wr_en && (wr_idx == IDX_TDEF);
    tdef_wr  = sel_tdef;
    addr_d   = sel_addr ? wr_data : bp_addr;
    mask_d   = sel_mask ? wr_data : bp_mask;
    l1_d     = sel_tdef ? wr_data[L1_BIT] : l1_en;
    l2_d     = sel_tdef ? wr_data[L2_BIT] : l2_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_addr <= '0;
      bp_mask <= '0;
      l1_en   <= 1'b0;
      l2_en   <= 1'b0;
    end else begin
      bp_addr <= addr_d;
      bp_mask <= mask_d;
      l1_en   <= l1_d;
      l2_en   <= l2_d;
    end
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_ADDR) |=> (bp_addr == $past(wr_data))); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_MASK) |=> (bp_mask == $past(wr_data))); // R2
  AST_FOREIGN_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != IDX_ADDR && wr_idx != IDX_MASK && wr_idx != IDX_TDEF)
    |=> ($stable(bp_addr) && $stable(bp_mask) && $stable(l1_en) && $stable(l2_en))); // R10
endmodule

// File: rtl/pcbk_cmp.sv
module pcbk_cmp #(
  parameter int AW = 32
) (
  input  logic          pc_valid,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] bp_addr,
  input  logic [AW-1:0] bp_mask,
  output logic          hit
);
  logic [AW-1:0] bit_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = bp_mask[i] | ~(pc[i] ^ bp_addr[i]);
  end

  assign hit = pc_valid & (&bit_ok);
endmodule

// File: rtl/pcbk_seq.sv
module pcbk_seq
  import pcbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic l1_en,
  input  logic l2_en,
  input  logic tdef_wr,
  output logic trig
);
  trig_mode_e mode;
  logic       armed, armed_d, fire, trig_d;

  always_comb begin
    unique case ({l1_en, l2_en})
      2'b00:   mode = MODE_OFF;
      2'b11:   mode = MODE_TWO;
      default: mode = MODE_ONE;
    endcase
    fire = hit && ((mode == MODE_ONE) || (mode == MODE_TWO && armed));
    trig_d = fire;
    if (tdef_wr)
      armed_d = 1'b0;
    else if (fire)
      armed_d = 1'b0;
    else if (mode == MODE_TWO && hit)
      armed_d = 1'b1;
    else
      armed_d = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      armed <= armed_d;
      trig  <= trig_d;
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!l1_en && !l2_en) |=> !trig); // R6
  AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_en && l2_en && !armed) |=> !trig); // R8
  AST_DISARM_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tdef_wr |=> !armed); // R9
  AST_TRIG_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(hit)); // R5
endmodule

// File: rtl/pc_break_trig.sv
module pc_break_trig
  import pcbk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic             pc_valid,
  input  logic [AW-1:0]    pc,
  output logic             trig_pulse
);
  logic          rst_meta, rst_sync;
  logic [AW-1:0] bp_addr, bp_mask;
  logic          l1_en, l2_en, tdef_wr, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pcbk_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .bp_addr(bp_addr), .bp_mask(bp_mask),
    .l1_en(l1_en), .l2_en(l2_en), .tdef_wr(tdef_wr)
  );

  pcbk_cmp #(.AW(AW)) u_cmp (
    .pc_valid(pc_valid), .pc(pc), .bp_addr(bp_addr), .bp_mask(bp_mask),
    .hit(hit)
  );

  pcbk_seq u_seq (
    .clk(clk), .rst_n(rst_sync), .hit(hit), .l1_en(l1_en), .l2_en(l2_en),
    .tdef_wr(tdef_wr), .trig(trig_pulse)
  );

  AST_NO_TRIG_IN_RESET: assert property (@(posedge clk)
    !rst_sync |=> !trig_pulse); // R1
endmodule

// File: tb/pc_break_trig_test.sv
module pc_break_trig_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        pc_valid;
  logic [31:0] pc;
  logic        trig_pulse;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [31:0] m_addr, m_mask, m_tdef;
  bit          m_armed, m_trig;
  int          rel_cnt;

  always #5 clk = ~clk;

  pc_break_trig uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .pc_valid(pc_valid), .pc(pc), .trig_pulse(trig_pulse)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_mask = 0; m_tdef = 0; m_armed = 0; m_trig = 0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      bit h, e1, e2, f;
      h  = pc_valid && (((pc ^ m_addr) & ~m_mask) == 32'h0);
      e1 = m_tdef[0];
      e2 = m_tdef[16];
      f  = h && ((e1 != e2) || (e1 && e2 && m_armed));
      if (wr_en && wr_idx == 5'h07) m_armed = 0;
      else if (f) m_armed = 0;
      else if (e1 && e2 && h) m_armed = 1;
      m_trig = f;
      if (wr_en && wr_idx == 5'h08) m_addr = wr_data;
      if (wr_en && wr_idx == 5'h09) m_mask = wr_data;
      if (wr_en && wr_idx == 5'h07) m_tdef = wr_data;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (trig_pulse !== m_trig) begin
        bad++;
        $display("FAIL %s: trig_pulse=%0b expected=%0b at %0t", cur_req, trig_pulse, m_trig, $time);
      end
    end
  end

  task automatic cyc(input bit we, input logic [4:0] idx, input logic [31:0] d,
                     input bit v, input logic [31:0] p);
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_data = d; pc_valid = v; pc = p;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    cyc(1, idx, d, 0, 32'h0);
  endtask

  task automatic pcs(input bit v, input logic [31:0] p);
    cyc(0, 5'h0, 32'h0, v, p);
  endtask

  task automatic expect_pulse(input string req, input bit exp);
    @(negedge clk);
    wr_en = 0; pc_valid = 0;
    total++;
    if (trig_pulse !== exp) begin
      bad++;
      $display("FAIL %s: trig_pulse=%0b expected=%0b", req, trig_pulse, exp);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0; pc_valid = 0; pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: all-zero state, PC 0 matches addr 0 but no level is enabled
    cur_req = "R1";
    pcs(1, 32'h0); expect_pulse("R1", 0);

    cur_req = "R2";
    wr(5'h08, 32'h1000_0040);
    wr(5'h09, 32'h0);
    wr(5'h07, 32'h0000_0001);
    pcs(1, 32'h1000_0040); expect_pulse("R2", 1);
    cur_req = "R4";
    pcs(0, 32'h1000_0040); expect_pulse("R4", 0);
    cur_req = "R3";
    pcs(1, 32'h1000_0041); expect_pulse("R3", 0);
    wr(5'h09, 32'h0000_00FF);
    pcs(1, 32'h1000_00A3); expect_pulse("R3", 1);
    pcs(1, 32'h1100_0040); expect_pulse("R3", 0);

    cur_req = "R5";
    pcs(1, 32'h1000_0040); pcs(0, 0); expect_pulse("R5", 0);

    cur_req = "R7";
    wr(5'h07, 32'h0001_0000);
    pcs(1, 32'h1000_0040); expect_pulse("R7", 1);
    pcs(1, 32'h1000_0040); pcs(1, 32'h1000_0041);

    cur_req = "R8";
    wr(5'h07, 32'h0001_0001);
    pcs(1, 32'h1000_0040); expect_pulse("R8", 0);
    pcs(1, 32'h1000_0040); expect_pulse("R8", 1);
    pcs(1, 32'h1000_0040); expect_pulse("R8", 0);
    pcs(1, 32'h1000_0040); expect_pulse("R8", 1);

    // R9: armed, then rewrite trigger word with a matching PC the same cycle
    cur_req = "R9";
    pcs(1, 32'h1000_0040);
    cyc(1, 5'h07, 32'h0001_0001, 1, 32'h1000_0040); expect_pulse("R9", 1);
    pcs(1, 32'h1000_0040); expect_pulse("R9", 0);
    wr(5'h07, 32'h0001_0001);
    pcs(1, 32'h1000_0040); expect_pulse("R9", 0);

    cur_req = "R10";
    wr(5'h0A, 32'h0);
    wr(5'h1F, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0);
    pcs(1, 32'h1000_0040); expect_pulse("R10", 1);

    cur_req = "R6";
    wr(5'h07, 32'hFFFE_FFFE);
    pcs(1, 32'h1000_0040); expect_pulse("R6", 0);
    pcs(1, 32'h1000_0040); expect_pulse("R6", 0);

    cur_req = "R9 random";
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [4:0]  idx;
      logic [31:0] d, p;
      k = $urandom_range(0, 9);
      idx = (k < 2) ? 5'h07 : (k == 2) ? 5'h08 : (k == 3) ? 5'h09 : 5'($urandom);
      d = $urandom;
      if (idx == 5'h09) d = d & 32'h0000_0F0F;
      if (idx == 5'h08) d = 32'h1000_0040 ^ (d & 32'h0000_0003);
      p = 32'h1000_0040 ^ ($urandom & 32'h0000_0107);
      cyc($urandom_range(0, 3) == 0, idx, d, $urandom_range(0, 3) != 0, p);
    end
    pcs(0, 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule